// File: doc/BRIEF.md
# Link Reset Retry Controller

This block brings up the link of one serial storage port whose PHY does not always train on the first hard reset. After a start pulse it runs a sequence of attempts. In each attempt it first switches off a per-lane receive override through a register master port. It then asks an external agent for a hard reset and waits for that agent to report completion and the online flag. After the reset it waits for the lane to leave half-rate mode, then sets the override again with a new DPLL mode and a pulsed DPLL reset. It then lets the PHY settle for a fixed number of milliseconds.

After each attempt the block looks at the online flag and at the link detect field. It stops when the device is absent, when the link is up, or when the retry budget is used up. It then reports the final online flag and the number of attempts it used. The reset signalling and device classification are handled by other logic.

All lane registers sit at a base address plus the lane number times 0x100. The status register base is 0x2002 and the override register base is 0x2005. The register data words are 16 bits wide.

Top module: `llr_ctrl`

## Requirements
- R1: A `start` pulse while `busy` is low latches `lane` and raises `busy` on the next cycle. A `start` pulse while `busy` is high is ignored: the access sequence and the lane do not change. While `busy` is low, neither `reg_req` nor `rst_req` is asserted.
- R2: Reads go to the status address 0x2002 + lane*0x100 and writes go to the override address 0x2005 + lane*0x100. Once `reg_req` is raised, it stays high with address, direction and write data unchanged until `reg_ack` is seen.
- R3: Each attempt begins with a status read. The value read, with bit 14 (override enable) cleared, is then written to the override register, and only after that is the reset requested.
- R4: `rst_req` stays high until `rst_done` and is never high together with `reg_req`. `rst_online` is captured in the cycle in which `rst_done` is high.
- R5: After the reset, the status register is read again and again while bit 0 (half rate) reads 1. There are at most POLL_MAX (default 1000) such reads in one attempt.
- R6: After polling, the block reads the status value V and writes the override register exactly five times, in this order: V with bit 14 cleared; then with bit 14 set; then with bits [10:8] replaced by 3; then with bit 11 set; then with bit 11 cleared.
- R7: After the fifth override write is acknowledged, there is no register request, reset request or `done` for at least SETTLE_MS*TICKS_PER_MS clock cycles.
- R8: If `link_det` (bits [1:0] of link status) is zero after the settle wait, the block finishes at once, whatever the online flag.
- R9: Otherwise the block finishes when the captured online flag is 1. If it is 0, the block starts a new attempt, up to MAX_RETRY+1 attempts in total (default 101).
- R10: On finishing, `done` is high for exactly one cycle, `busy` falls in that same cycle, and `done_online` and `done_attempts` give the last online flag and the number of attempts made.
- R11: After reset, `busy`, `done`, `reg_req` and `rst_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse for a bring-up run |
| lane | input | LANE_W | Lane index within the PHY, latched on start |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when a run finishes |
| done_online | output | 1 | Online flag of the last attempt |
| done_attempts | output | ATT_W | Attempts used by the run |
| rst_req | output | 1 | Hard-reset request, held until complete |
| rst_done | input | 1 | Hard-reset completion pulse |
| rst_online | input | 1 | Link online flag, valid with rst_done |
| link_det | input | 2 | Link status detect field |
| reg_req | output | 1 | Register access request, held until ack |
| reg_wr | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 16 | Register address |
| reg_wdata | output | 16 | Write data |
| reg_ack | input | 1 | Access acknowledge, read data valid |
| reg_rdata | input | 16 | Read data |

## Verification
The hardest state to reach is the end of the retry budget: the link never comes online while the detect field stays non-zero, and this has to hold for 101 full attempts. The bench's reset responder reports offline on every attempt, and the settle time is shortened with a small tick divider so that the whole budget runs in about ten thousand cycles. The half-rate poll cap is reached in a similar way: the register slave keeps bit 0 set for more reads than the cap allows. In both cases every expected access, with its address and data, is queued in advance from the requirements.

// File: rtl/llr_pkg.sv
package llr_pkg;

    localparam int WORD_W = 16;
    typedef logic [WORD_W-1:0] word_t;

    localparam word_t STS_BASE    = 16'h2002;
    localparam word_t OVR_BASE    = 16'h2005;
    localparam word_t LANE_STRIDE = 16'h0100;

    localparam int HALF_RATE_BIT = 0;
    localparam word_t OVR_EN     = 16'h4000;
    localparam word_t DPLL_MASK  = 16'h0700;
    localparam word_t DPLL_VAL   = 16'h0300;
    localparam word_t DPLL_RST   = 16'h0800;
    localparam int OVR_STEPS     = 5;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE_RD,
        ST_PRE_WR,
        ST_RESET,
        ST_POLL,
        ST_OV_RD,
        ST_OV_WR,
        ST_SETTLE,
        ST_DECIDE
    } state_t;

    typedef struct packed {
        logic  wr;
        word_t addr;
        word_t wdata;
    } cmd_t;

    function automatic word_t lane_addr(word_t base, int unsigned lane_idx);
        return base + word_t'(lane_idx) * LANE_STRIDE;
    endfunction

    function automatic word_t ovr_value(word_t base, logic [2:0] step);
        word_t v;
        v = base & ~OVR_EN;
        if (step >= 3'd1) v = v | OVR_EN;
        if (step >= 3'd2) v = (v & ~DPLL_MASK) | DPLL_VAL;
        if (step >= 3'd3) v = v | DPLL_RST;
        if (step >= 3'd4) v = v & ~DPLL_RST;
        return v;
    endfunction

endpackage

// File: rtl/llr_reg_port.sv
module llr_reg_port
    import llr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  go,
    input  cmd_t  cmd,
    output logic  cmd_done,
    output word_t cmd_rdata,
    output logic  reg_req,
    output logic  reg_wr,
    output word_t reg_addr,
    output word_t reg_wdata,
    input  logic  reg_ack,
    input  word_t reg_rdata
);
    logic  req_q;
    cmd_t  cmd_q;
    logic  done_q;
    word_t rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= 1'b0;
            cmd_q   <= '0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (req_q) begin
                if (reg_ack) begin
                    req_q   <= 1'b0;
                    done_q  <= 1'b1;
                    rdata_q <= reg_rdata;
                end
            end else if (go) begin
                req_q <= 1'b1;
                cmd_q <= cmd;
            end
        end
    end

    assign reg_req   = req_q;
    assign reg_wr    = cmd_q.wr;
    assign reg_addr  = cmd_q.addr;
    assign reg_wdata = cmd_q.wdata;
    assign cmd_done  = done_q;
    assign cmd_rdata = rdata_q;
endmodule

// File: rtl/llr_settle_timer.sv
module llr_settle_timer #(
    parameter int SETTLE_MS    = 15,
    parameter int TICKS_PER_MS = 200000,
    localparam int TW = $clog2(TICKS_PER_MS + 1),
    localparam int MW = $clog2(SETTLE_MS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic expired
);
    logic [TW-1:0] tick_q;
    logic [MW-1:0] ms_q;
    logic          run_q;
    logic          exp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= '0;
            ms_q   <= '0;
            run_q  <= 1'b0;
            exp_q  <= 1'b0;
        end else begin
            exp_q <= 1'b0;
            if (go && !run_q) begin
                tick_q <= TW'(TICKS_PER_MS - 1);
                ms_q   <= MW'(SETTLE_MS);
                run_q  <= 1'b1;
            end else if (run_q) begin
                if (tick_q == '0) begin
                    tick_q <= TW'(TICKS_PER_MS - 1);
                    if (ms_q == MW'(1)) begin
                        run_q <= 1'b0;
                        exp_q <= 1'b1;
                    end else begin
                        ms_q <= ms_q - MW'(1);
                    end
                end else begin
                    tick_q <= tick_q - TW'(1);
                end
            end
        end
    end

    assign expired = exp_q;
endmodule

// File: rtl/llr_ctrl.sv
module llr_ctrl
    import llr_pkg::*;
#(
    parameter int LANE_W       = 2,
    parameter int POLL_MAX     = 1000,
    parameter int MAX_RETRY    = 100,
    parameter int SETTLE_MS    = 15,
    parameter int TICKS_PER_MS = 200000,
    localparam int ATT_W = $clog2(MAX_RETRY + 2),
    localparam int PW    = $clog2(POLL_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LANE_W-1:0] lane,
    output logic              busy,
    output logic              done,
    output logic              done_online,
    output logic [ATT_W-1:0]  done_attempts,
    output logic              rst_req,
    input  logic              rst_done,
    input  logic              rst_online,
    input  logic [1:0]        link_det,
    output logic              reg_req,
    output logic              reg_wr,
    output logic [15:0]       reg_addr,
    output logic [15:0]       reg_wdata,
    input  logic              reg_ack,
    input  logic [15:0]       reg_rdata
);
    localparam logic [2:0] LAST_STEP = 3'(OVR_STEPS - 1);

    state_t            state_q;
    logic              wait_q;
    logic [LANE_W-1:0] lane_q;
    word_t             base_q;
    logic [2:0]        step_q;
    logic [PW-1:0]     poll_q;
    logic [ATT_W-1:0]  att_q;
    logic              online_q;
    logic              done_q;
    logic              rst_req_q;

    logic  cmd_go;
    cmd_t  cmd;
    logic  cmd_done;
    word_t cmd_rdata;
    logic  tmr_go;
    logic  tmr_exp;
    logic  is_cmd_state;
    logic  is_wr_state;

    always_comb begin
        is_cmd_state = (state_q == ST_PRE_RD) || (state_q == ST_PRE_WR) ||
                       (state_q == ST_POLL)   || (state_q == ST_OV_RD)  ||
                       (state_q == ST_OV_WR);
        is_wr_state  = (state_q == ST_PRE_WR) || (state_q == ST_OV_WR);
        cmd_go       = is_cmd_state && !wait_q;
        cmd.wr       = is_wr_state;
        cmd.addr     = is_wr_state ? lane_addr(OVR_BASE, int'(lane_q))
                                   : lane_addr(STS_BASE, int'(lane_q));
        cmd.wdata    = ovr_value(base_q, (state_q == ST_PRE_WR) ? 3'd0 : step_q);
        tmr_go       = (state_q == ST_SETTLE) && !wait_q;
    end

    llr_reg_port u_port (
        .clk       (clk),
        .rst       (rst),
        .go        (cmd_go),
        .cmd       (cmd),
        .cmd_done  (cmd_done),
        .cmd_rdata (cmd_rdata),
        .reg_req   (reg_req),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_ack   (reg_ack),
        .reg_rdata (reg_rdata)
    );

    llr_settle_timer #(
        .SETTLE_MS    (SETTLE_MS),
        .TICKS_PER_MS (TICKS_PER_MS)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .go      (tmr_go),
        .expired (tmr_exp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            wait_q    <= 1'b0;
            lane_q    <= '0;
            base_q    <= '0;
            step_q    <= '0;
            poll_q    <= '0;
            att_q     <= '0;
            online_q  <= 1'b0;
            done_q    <= 1'b0;
            rst_req_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        lane_q  <= lane;
                        att_q   <= ATT_W'(1);
                        wait_q  <= 1'b0;
                        state_q <= ST_PRE_RD;
                    end
                end
                ST_PRE_RD: begin
                    if (!wait_q) begin
                        wait_q <= 1'b1;
                    end else if (cmd_done) begin
                        base_q  <= cmd_rdata;
                        wait_q  <= 1'b0;
                        state_q <= ST_PRE_WR;
                    end
                end
                ST_PRE_WR: begin
                    if (!wait_q) begin
                        wait_q <= 1'b1;
                    end else if (cmd_done) begin
                        wait_q  <= 1'b0;
                        state_q <= ST_RESET;
                    end
                end
                ST_RESET: begin
                    if (!wait_q) begin
                        wait_q    <= 1'b1;
                        rst_req_q <= 1'b1;
                    end else if (rst_done) begin
                        rst_req_q <= 1'b0;
                        online_q  <= rst_online;
                        poll_q    <= '0;
                        wait_q    <= 1'b0;
                        state_q   <= ST_POLL;
                    end
                end
                ST_POLL: begin
                    if (!wait_q) begin
                        wait_q <= 1'b1;
                    end else if (cmd_done) begin
                        wait_q <= 1'b0;
                        poll_q <= poll_q + PW'(1);
                        if (!(cmd_rdata[HALF_RATE_BIT] &&
                              (int'(poll_q) + 1 < POLL_MAX))) begin
                            state_q <= ST_OV_RD;
                        end
                    end
                end
                ST_OV_RD: begin
                    if (!wait_q) begin
                        wait_q <= 1'b1;
                    end else if (cmd_done) begin
                        base_q  <= cmd_rdata;
                        step_q  <= 3'd0;
                        wait_q  <= 1'b0;
                        state_q <= ST_OV_WR;
                    end
                end
                ST_OV_WR: begin
                    if (!wait_q) begin
                        wait_q <= 1'b1;
                    end else if (cmd_done) begin
                        wait_q <= 1'b0;
                        if (step_q == LAST_STEP) begin
                            state_q <= ST_SETTLE;
                        end else begin
                            step_q <= step_q + 3'd1;
                        end
                    end
                end
                ST_SETTLE: begin
                    if (!wait_q) begin
                        wait_q <= 1'b1;
                    end else if (tmr_exp) begin
                        wait_q  <= 1'b0;
                        state_q <= ST_DECIDE;
                    end
                end
                ST_DECIDE: begin
                    if ((link_det == 2'b00) || online_q ||
                        (int'(att_q) == MAX_RETRY + 1)) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        att_q   <= att_q + ATT_W'(1);
                        state_q <= ST_PRE_RD;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy          = (state_q != ST_IDLE);
    assign done          = done_q;
    assign done_online   = online_q;
    assign done_attempts = att_q;
    assign rst_req       = rst_req_q;
endmodule

// File: rtl/llr_ctrl_chk.sv
module llr_ctrl_chk #(
    parameter int MAX_RETRY = 100,
    parameter int ATT_W     = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             done,
    input logic [ATT_W-1:0] done_attempts,
    input logic             rst_req,
    input logic             rst_done,
    input logic             reg_req,
    input logic             reg_wr,
    input logic [15:0]      reg_addr,
    input logic [15:0]      reg_wdata,
    input logic             reg_ack
);
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
        reg_req && !reg_ack |=> reg_req && $stable(reg_addr) &&
                                $stable(reg_wr) && $stable(reg_wdata));

    assert_rst_hold_R4: assert property (@(posedge clk) disable iff (rst)
        rst_req && !rst_done |=> rst_req);

    assert_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(reg_req && rst_req));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !reg_req && !rst_req);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_budget_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (int'(done_attempts) >= 1) &&
                 (int'(done_attempts) <= MAX_RETRY + 1));
endmodule

bind llr_ctrl llr_ctrl_chk #(
    .MAX_RETRY (MAX_RETRY),
    .ATT_W     (ATT_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .busy          (busy),
    .done          (done),
    .done_attempts (done_attempts),
    .rst_req       (rst_req),
    .rst_done      (rst_done),
    .reg_req       (reg_req),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_ack       (reg_ack)
);

// File: tb/llr_ctrl_tb.sv
`timescale 1ns/1ps
module llr_ctrl_tb;
    localparam int TICKS  = 4;
    localparam int SETTLE = 15;
    localparam int POLLM  = 1000;
    localparam int MAXR   = 100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  lane_in = '0;
    logic        busy, done, done_online;
    logic [6:0]  done_attempts;
    logic        rst_req;
    logic        rst_done = 1'b0;
    logic        rst_online = 1'b0;
    logic [1:0]  link_det = 2'b11;
    logic        reg_req, reg_wr;
    logic [15:0] reg_addr, reg_wdata;
    logic        reg_ack = 1'b0;
    logic [15:0] reg_rdata = '0;

    always #2.5 clk = ~clk;

    llr_ctrl #(.TICKS_PER_MS(TICKS)) u_dut (
        .clk(clk), .rst(rst), .start(start), .lane(lane_in),
        .busy(busy), .done(done), .done_online(done_online),
        .done_attempts(done_attempts), .rst_req(rst_req),
        .rst_done(rst_done), .rst_online(rst_online), .link_det(link_det),
        .reg_req(reg_req), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata)
    );

    typedef struct {
        bit          wr;
        logic [15:0] addr;
        logic [15:0] data;
        bit          last;
        string       req;
    } acc_t;

    acc_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    int   cycles   = 0;

    int   sc_online_at, sc_det0_at, att_seen;
    int   done_cnt = 0;
    logic done_on_cap;
    int   done_att_cap;
    logic done_busy_cap;
    int   ack_dly = 1, ack_tog = 0, rst_dly = 0;
    bit   settle_armed = 0;
    int   settle_gap = 0;

    task automatic chk(bit ok, string req, string what, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    function automatic void push(bit wr, logic [15:0] a, logic [15:0] d, bit last, string r);
        acc_t e;
        e.wr = wr; e.addr = a; e.data = d; e.last = last; e.req = r;
        exp_q.push_back(e);
    endfunction

    function automatic void build(int lane, logic [15:0] s, int hr, int n_att);
        logic [15:0] sa, oa, t;
        int n;
        sa = 16'h2002 + 16'(lane) * 16'h0100;
        oa = 16'h2005 + 16'(lane) * 16'h0100;
        for (int a = 0; a < n_att; a++) begin
            push(0, sa, s, 0, "R3");
            push(1, oa, s & ~16'h4000, 0, "R3");
            n = (hr + 1 < POLLM) ? hr + 1 : POLLM;
            for (int i = 0; i < n; i++)
                push(0, sa, (i < hr) ? (s | 16'h0001) : s, 0, "R5");
            push(0, sa, s, 0, "R6");
            t = s & ~16'h4000;            push(1, oa, t, 0, "R6");
            t = t | 16'h4000;             push(1, oa, t, 0, "R6");
            t = (t & ~16'h0700) | 16'h0300; push(1, oa, t, 0, "R6");
            t = t | 16'h0800;             push(1, oa, t, 0, "R6");
            t = t & ~16'h0800;            push(1, oa, t, 1, "R6");
        end
    endfunction

    // All bench-side responders and monitors in one ordered loop per negedge
    initial begin
        forever begin
            @(negedge clk);
            cycles++;
            if (cycles > 180000) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual %0d expected <180000 cycles", cycles);
                finish_run();
            end
            // monitor
            if (done) begin
                done_cnt++;
                done_on_cap   = done_online;
                done_att_cap  = int'(done_attempts);
                done_busy_cap = busy;
            end
            if (reg_req || rst_req)
                chk(busy, "R1", "busy during activity", busy, 1);
            if (settle_armed) begin
                if (reg_req || rst_req || done) begin
                    chk(settle_gap >= SETTLE * TICKS, "R7", "settle gap",
                        settle_gap, SETTLE * TICKS);
                    settle_armed = 0;
                end else begin
                    settle_gap++;
                end
            end
            // register slave
            if (reg_ack) begin
                reg_ack = 1'b0;
            end else if (reg_req) begin
                if (ack_dly == 0) begin
                    if (exp_q.size() == 0) begin
                        chk(0, "R2", "unexpected access addr", int'(reg_addr), 0);
                    end else begin
                        acc_t e;
                        e = exp_q.pop_front();
                        chk(reg_wr == e.wr, e.req, "direction", reg_wr, e.wr);
                        chk(reg_addr == e.addr, "R2", "address", reg_addr, e.addr);
                        if (e.wr)
                            chk(reg_wdata == e.data, e.req, "write data", reg_wdata, e.data);
                        reg_rdata = e.data;
                        if (e.last) begin
                            settle_armed = 1;
                            settle_gap   = 0;
                        end
                    end
                    reg_ack = 1'b1;
                    ack_tog = 1 - ack_tog;
                    ack_dly = ack_tog;
                end else begin
                    ack_dly--;
                end
            end
            // reset responder
            if (rst_done) begin
                rst_done = 1'b0;
            end else if (rst_req) begin
                rst_dly++;
                if (rst_dly == 3) begin
                    rst_dly = 0;
                    att_seen++;
                    rst_online = (att_seen == sc_online_at);
                    link_det   = (att_seen == sc_det0_at) ? 2'b00 : 2'b11;
                    rst_done   = 1'b1;
                end
            end
        end
    end

    task automatic run(int lane, logic [15:0] s, int hr, int online_at, int det0_at,
                       int exp_att, bit exp_on, bit extra_start, string req);
        int d0;
        sc_online_at = online_at;
        sc_det0_at   = det0_at;
        att_seen     = 0;
        exp_q.delete();
        build(lane, s, hr, exp_att);
        d0 = done_cnt;
        @(negedge clk);
        start   = 1'b1;
        lane_in = 2'(lane);
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R1", "busy after start", busy, 1);
        if (extra_start) begin
            repeat (20) @(negedge clk);
            start   = 1'b1;
            lane_in = 2'(lane) ^ 2'b11;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_cnt == d0) @(negedge clk);
        chk(done_on_cap == exp_on, req, "done_online", done_on_cap, exp_on);
        chk(done_att_cap == exp_att, req, "done_attempts", done_att_cap, exp_att);
        chk(!done_busy_cap, "R10", "busy at done", done_busy_cap, 0);
        chk(exp_q.size() == 0, "R5", "accesses left over", exp_q.size(), 0);
        @(negedge clk);
        chk(!done, "R10", "done width", done, 0);
        repeat (40) @(negedge clk);
        chk(done_cnt == d0 + 1, "R10", "done count", done_cnt - d0, 1);
        chk(!reg_req && !rst_req, "R1", "quiet after done", reg_req | rst_req, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(!busy && !done, "R11", "busy/done in reset", busy | done, 0);
        chk(!reg_req && !rst_req, "R11", "requests in reset", reg_req | rst_req, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy, "R11", "busy after reset", busy, 0);

        // online on first attempt, a few half-rate reads
        run(1, 16'h4A50, 3, 1, 0, 1, 1'b1, 1'b0, "R9");
        // online on fourth attempt, start pulse mid-run ignored
        run(3, 16'h5C34, 0, 4, 0, 4, 1'b1, 1'b1, "R1");
        // no device detected on second attempt
        run(0, 16'h4F0E, 1, 0, 2, 2, 1'b0, 1'b0, "R8");
        // detect zero wins over online on same attempt
        run(2, 16'h0622, 2, 1, 1, 1, 1'b1, 1'b0, "R8");
        // half-rate never clears: poll cap
        run(0, 16'h7AF0, 1500, 1, 0, 1, 1'b1, 1'b0, "R5");
        // never online: full retry budget
        run(2, 16'h4102, 0, 0, 0, MAXR + 1, 1'b0, 1'b0, "R9");

        finish_run();
    end
endmodule